// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block chooses the setting that drives a clock synthesizer. At power-up it captures a five-bit frequency-select strap code once, on the first cycle where the active-low power-good strobe is seen low. After that it ignores both the strobe and the straps. From then on it picks the active setting from one of three places: the captured straps, a software select code, or a programmed N/M divider pair. The output frequency then follows G·(N+3)/(M+3).

The block publishes the effective setting as a registered tuple: the ratio code, N, M, and a flag that says whether the divider pair is in use. It also shows which source is active. It raises a one-cycle load strobe for the PLL and a one-cycle change pulse for a watchdog and reset generator. A watchdog can put the block in recovery mode. In that mode the block runs from a recovery source and locks out further host changes until the request drops.

Top module: `freq_src_sel`

## Requirements
- R1: While reset is held, and on every cycle before the straps are captured, code_o, n_o, m_o, nm_o and src_o are 0, and load_o, chg_o and err_o are low.
- R2: The strap code is captured on the first rising clock edge at which pwrgd_ni is low. Later values of pwrgd_ni and strap_i have no effect on code_o.
- R3: Outside recovery with prog_en_i low, the block runs from the captured straps, or from sw_code_i when override_i is 1. In both cases nm_o=0, n_o=m_o=0, and src_o=0 (straps) or 1 (software code).
- R4: Outside recovery with prog_en_i high, the block sets nm_o=1, n_o=prog_n_i, m_o=prog_m_i and src_o=2. code_o is sw_code_i when override_i is 1 and the straps otherwise.
- R5: Every output reflects the inputs sampled at the previous rising edge. chg_o pulses for one cycle exactly when the (code, N, M, nm) tuple changes, and load_o is high in that cycle too.
- R6: Outside recovery with prog_en_i high, a pulse on prog_n_we_i or prog_m_we_i raises load_o one cycle later, even when the values are unchanged. chg_o stays low in that case.
- R7: A selected divider pair with N <= M is rejected. err_o goes high, every tuple output holds its previous value, and load_o and chg_o stay low.
- R8: In recovery with rcv_sel_i at 0, the block uses the straps with nm_o=0 and src_o=0. With rcv_sel_i at 1 it uses rcv_n_i/rcv_m_i with nm_o=1 and src_o=3, and code_o is sw_code_i if override_i is 1 and the straps otherwise.
- R9: The recovery inputs (override_i, sw_code_i, rcv_sel_i, rcv_n_i, rcv_m_i) are captured on the edge that first sees recovery_i high. While recovery lasts, changes to any host frequency field or write strobe alter no output and raise no load.
- R10: When recovery_i drops, the live host fields take effect again on the next edge, with a change pulse if the tuple differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | CODE_W | Frequency-select strap pins |
| pwrgd_ni | input | 1 | Active-low power-good strobe that qualifies the straps |
| prog_en_i | input | 1 | Programmable divider mode enable |
| override_i | input | 1 | 1 selects sw_code_i in place of the straps |
| sw_code_i | input | CODE_W | Software select code |
| prog_n_i | input | N_W | Programmed N value |
| prog_m_i | input | M_W | Programmed M value |
| prog_n_we_i | input | 1 | Write strobe for the N register |
| prog_m_we_i | input | 1 | Write strobe for the M register |
| recovery_i | input | 1 | Watchdog recovery request, held high while active |
| rcv_sel_i | input | 1 | Recovery source: 0 straps, 1 recovery N/M pair |
| rcv_n_i | input | N_W | Recovery N value |
| rcv_m_i | input | M_W | Recovery M value |
| code_o | output | CODE_W | Effective ratio / gear code |
| n_o | output | N_W | Effective N (0 when nm_o is low) |
| m_o | output | M_W | Effective M (0 when nm_o is low) |
| nm_o | output | 1 | Divider pair in use |
| src_o | output | 2 | Active source: 0 straps, 1 software code, 2 programmed pair, 3 recovery pair |
| load_o | output | 1 | One-cycle PLL load strobe |
| chg_o | output | 1 | One-cycle effective-tuple change pulse |
| err_o | output | 1 | Rejected divider pair (N <= M) |

## Verification
The bench builds the block with its default widths: a 5-bit code, an 8-bit N and a 7-bit M. At these widths every M value and the full N range can be driven. The directed part covers the N = M boundary, N one above M, and N below M. The random part drives pairs near the boundary, rewrites of unchanged values, and recovery entry and exit mixed with host writes during lockout. The power-good strobe and the straps keep toggling throughout, long after capture.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int SRC_W = 2;
  typedef enum logic [SRC_W-1:0] {
    SRC_STRAP = 2'd0,
    SRC_SOFT  = 2'd1,
    SRC_PROG  = 2'd2,
    SRC_RCVNM = 2'd3
  } fsrc_e;
endpackage

// File: rtl/fss_strap_latch.sv
module fss_strap_latch #(
  parameter int CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] strap_i,
  input  logic              pwrgd_ni,
  output logic [CODE_W-1:0] strap_o,
  output logic              ok_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_o <= '0;
      ok_o    <= 1'b0;
    end else if (!ok_o && !pwrgd_ni) begin
      strap_o <= strap_i;
      ok_o    <= 1'b1;
    end
  end
endmodule

// File: rtl/fss_rcv_hold.sv
module fss_rcv_hold #(
  parameter int CODE_W = 5,
  parameter int N_W    = 8,
  parameter int M_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              recovery_i,
  input  logic              ovr_i,
  input  logic [CODE_W-1:0] sw_i,
  input  logic              sel_i,
  input  logic [N_W-1:0]    rn_i,
  input  logic [M_W-1:0]    rm_i,
  output logic              ovr_o,
  output logic [CODE_W-1:0] sw_o,
  output logic              sel_o,
  output logic [N_W-1:0]    rn_o,
  output logic [M_W-1:0]    rm_o
);
  logic              rec_q;
  logic              ovr_s, sel_s;
  logic [CODE_W-1:0] sw_s;
  logic [N_W-1:0]    rn_s;
  logic [M_W-1:0]    rm_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q <= 1'b0;
      ovr_s <= 1'b0;
      sel_s <= 1'b0;
      sw_s  <= '0;
      rn_s  <= '0;
      rm_s  <= '0;
    end else begin
      rec_q <= recovery_i;
      if (recovery_i && !rec_q) begin
        ovr_s <= ovr_i;
        sel_s <= sel_i;
        sw_s  <= sw_i;
        rn_s  <= rn_i;
        rm_s  <= rm_i;
      end
    end
  end

  // entry cycle sees live fields, which are the ones being captured
  assign ovr_o = rec_q ? ovr_s : ovr_i;
  assign sel_o = rec_q ? sel_s : sel_i;
  assign sw_o  = rec_q ? sw_s  : sw_i;
  assign rn_o  = rec_q ? rn_s  : rn_i;
  assign rm_o  = rec_q ? rm_s  : rm_i;
endmodule

// File: rtl/fss_src_mux.sv
module fss_src_mux
  import fss_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int N_W    = 8,
  parameter int M_W    = 7
) (
  input  logic              in_rcv_i,
  input  logic [CODE_W-1:0] strap_i,
  input  logic              ovr_i,
  input  logic [CODE_W-1:0] sw_i,
  input  logic              prog_en_i,
  input  logic [N_W-1:0]    pn_i,
  input  logic [M_W-1:0]    pm_i,
  input  logic              h_ovr_i,
  input  logic [CODE_W-1:0] h_sw_i,
  input  logic              h_sel_i,
  input  logic [N_W-1:0]    h_rn_i,
  input  logic [M_W-1:0]    h_rm_i,
  output logic [CODE_W-1:0] code_o,
  output logic [N_W-1:0]    n_o,
  output logic [M_W-1:0]    m_o,
  output logic              nm_o,
  output fsrc_e             src_o,
  output logic              err_o
);
  localparam int CMP_W = ((N_W > M_W) ? N_W : M_W) + 1;

  logic [CMP_W-1:0] n_ext, m_ext;

  always_comb begin
    code_o = strap_i;
    n_o    = '0;
    m_o    = '0;
    nm_o   = 1'b0;
    src_o  = SRC_STRAP;
    if (in_rcv_i) begin
      if (h_sel_i) begin
        code_o = h_ovr_i ? h_sw_i : strap_i;
        n_o    = h_rn_i;
        m_o    = h_rm_i;
        nm_o   = 1'b1;
        src_o  = SRC_RCVNM;
      end
    end else if (prog_en_i) begin
      code_o = ovr_i ? sw_i : strap_i;
      n_o    = pn_i;
      m_o    = pm_i;
      nm_o   = 1'b1;
      src_o  = SRC_PROG;
    end else if (ovr_i) begin
      code_o = sw_i;
      src_o  = SRC_SOFT;
    end
  end

  // (N+3) > (M+3) reduces to N > M
  assign n_ext = CMP_W'(n_o);
  assign m_ext = CMP_W'(m_o);
  assign err_o = nm_o && (n_ext <= m_ext);
endmodule

// File: rtl/fss_load_gen.sv
module fss_load_gen
  import fss_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int N_W    = 8,
  parameter int M_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ok_i,
  input  logic [CODE_W-1:0] cand_code_i,
  input  logic [N_W-1:0]    cand_n_i,
  input  logic [M_W-1:0]    cand_m_i,
  input  logic              cand_nm_i,
  input  fsrc_e             cand_src_i,
  input  logic              cand_err_i,
  input  logic              wr_trig_i,
  output logic [CODE_W-1:0] code_o,
  output logic [N_W-1:0]    n_o,
  output logic [M_W-1:0]    m_o,
  output logic              nm_o,
  output fsrc_e             src_o,
  output logic              load_o,
  output logic              chg_o,
  output logic              err_o
);
  logic diff;

  assign diff = (cand_code_i != code_o) || (cand_n_i != n_o) ||
                (cand_m_i != m_o) || (cand_nm_i != nm_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= '0;
      n_o    <= '0;
      m_o    <= '0;
      nm_o   <= 1'b0;
      src_o  <= SRC_STRAP;
      load_o <= 1'b0;
      chg_o  <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      load_o <= 1'b0;
      chg_o  <= 1'b0;
      err_o  <= 1'b0;
      if (ok_i) begin
        if (cand_err_i) begin
          err_o <= 1'b1;
        end else begin
          code_o <= cand_code_i;
          n_o    <= cand_n_i;
          m_o    <= cand_m_i;
          nm_o   <= cand_nm_i;
          src_o  <= cand_src_i;
          chg_o  <= diff;
          load_o <= diff | wr_trig_i;
        end
      end
    end
  end
endmodule

// File: rtl/freq_src_sel.sv
module freq_src_sel
  import fss_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int N_W    = 8,
  parameter int M_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] strap_i,
  input  logic              pwrgd_ni,
  input  logic              prog_en_i,
  input  logic              override_i,
  input  logic [CODE_W-1:0] sw_code_i,
  input  logic [N_W-1:0]    prog_n_i,
  input  logic [M_W-1:0]    prog_m_i,
  input  logic              prog_n_we_i,
  input  logic              prog_m_we_i,
  input  logic              recovery_i,
  input  logic              rcv_sel_i,
  input  logic [N_W-1:0]    rcv_n_i,
  input  logic [M_W-1:0]    rcv_m_i,
  output logic [CODE_W-1:0] code_o,
  output logic [N_W-1:0]    n_o,
  output logic [M_W-1:0]    m_o,
  output logic              nm_o,
  output logic [SRC_W-1:0]  src_o,
  output logic              load_o,
  output logic              chg_o,
  output logic              err_o
);
  logic [CODE_W-1:0] strap_q;
  logic              strap_ok;
  logic              h_ovr, h_sel;
  logic [CODE_W-1:0] h_sw;
  logic [N_W-1:0]    h_rn;
  logic [M_W-1:0]    h_rm;
  logic [CODE_W-1:0] c_code;
  logic [N_W-1:0]    c_n;
  logic [M_W-1:0]    c_m;
  logic              c_nm, c_err, wr_trig;
  fsrc_e             c_src, q_src;

  fss_strap_latch #(.CODE_W(CODE_W)) u_strap (
    .clk_i, .rst_ni, .strap_i, .pwrgd_ni,
    .strap_o(strap_q), .ok_o(strap_ok)
  );

  fss_rcv_hold #(.CODE_W(CODE_W), .N_W(N_W), .M_W(M_W)) u_hold (
    .clk_i, .rst_ni, .recovery_i,
    .ovr_i(override_i), .sw_i(sw_code_i), .sel_i(rcv_sel_i),
    .rn_i(rcv_n_i), .rm_i(rcv_m_i),
    .ovr_o(h_ovr), .sw_o(h_sw), .sel_o(h_sel), .rn_o(h_rn), .rm_o(h_rm)
  );

  fss_src_mux #(.CODE_W(CODE_W), .N_W(N_W), .M_W(M_W)) u_mux (
    .in_rcv_i(recovery_i), .strap_i(strap_q),
    .ovr_i(override_i), .sw_i(sw_code_i), .prog_en_i,
    .pn_i(prog_n_i), .pm_i(prog_m_i),
    .h_ovr_i(h_ovr), .h_sw_i(h_sw), .h_sel_i(h_sel), .h_rn_i(h_rn), .h_rm_i(h_rm),
    .code_o(c_code), .n_o(c_n), .m_o(c_m), .nm_o(c_nm), .src_o(c_src), .err_o(c_err)
  );

  // rewrites reload the PLL only outside recovery lockout
  assign wr_trig = !recovery_i && prog_en_i && (prog_n_we_i || prog_m_we_i);

  fss_load_gen #(.CODE_W(CODE_W), .N_W(N_W), .M_W(M_W)) u_load (
    .clk_i, .rst_ni, .ok_i(strap_ok),
    .cand_code_i(c_code), .cand_n_i(c_n), .cand_m_i(c_m), .cand_nm_i(c_nm),
    .cand_src_i(c_src), .cand_err_i(c_err), .wr_trig_i(wr_trig),
    .code_o, .n_o, .m_o, .nm_o, .src_o(q_src), .load_o, .chg_o, .err_o
  );

  assign src_o = q_src;
endmodule

// File: rtl/fss_checker.sv
module fss_checker #(
  parameter int CODE_W = 5,
  parameter int N_W    = 8,
  parameter int M_W    = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              recovery_i,
  input logic              strap_ok_i,
  input logic [CODE_W-1:0] strap_q_i,
  input logic [CODE_W-1:0] code_o,
  input logic [N_W-1:0]    n_o,
  input logic [M_W-1:0]    m_o,
  input logic              nm_o,
  input logic              load_o,
  input logic              chg_o,
  input logic              err_o
);
  localparam int CMP_W = ((N_W > M_W) ? N_W : M_W) + 1;

  p_prelatch_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strap_ok_i |-> (code_o == '0) && !load_o && !chg_o);

  p_strap_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_ok_i && $past(strap_ok_i) |-> $stable(strap_q_i));

  p_chg_has_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> load_o);

  p_err_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(code_o) && $stable(n_o) && $stable(m_o) && !load_o);

  p_pair_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nm_o |-> (CMP_W'(n_o) > CMP_W'(m_o)));

  p_rcv_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(recovery_i) && $past(recovery_i, 2) && $past(strap_ok_i, 2) |-> !load_o);
endmodule

bind freq_src_sel fss_checker #(.CODE_W(CODE_W), .N_W(N_W), .M_W(M_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .recovery_i(recovery_i),
  .strap_ok_i(strap_ok), .strap_q_i(strap_q),
  .code_o(code_o), .n_o(n_o), .m_o(m_o), .nm_o(nm_o),
  .load_o(load_o), .chg_o(chg_o), .err_o(err_o)
);

// File: tb/freq_src_sel_test.sv
module freq_src_sel_test;
  localparam int CLK_P  = 10;
  localparam int CODE_W = 5;
  localparam int N_W    = 8;
  localparam int M_W    = 7;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic [CODE_W-1:0] strap_i, sw_code_i;
  logic              pwrgd_ni, prog_en_i, override_i, prog_n_we_i, prog_m_we_i;
  logic [N_W-1:0]    prog_n_i, rcv_n_i;
  logic [M_W-1:0]    prog_m_i, rcv_m_i;
  logic              recovery_i, rcv_sel_i;
  logic [CODE_W-1:0] code_o;
  logic [N_W-1:0]    n_o;
  logic [M_W-1:0]    m_o;
  logic              nm_o, load_o, chg_o, err_o;
  logic [1:0]        src_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // expected-state model
  logic              e_lat = 0, e_rec = 0;
  logic [CODE_W-1:0] e_strap = '0, e_code = '0;
  logic [N_W-1:0]    e_n = '0;
  logic [M_W-1:0]    e_m = '0;
  logic              e_nm = 0, e_load = 0, e_chg = 0, e_err = 0;
  logic [1:0]        e_src = '0;
  logic              s_ovr = 0, s_sel = 0;
  logic [CODE_W-1:0] s_sw = '0;
  logic [N_W-1:0]    s_rn = '0;
  logic [M_W-1:0]    s_rm = '0;

  always #(CLK_P/2) clk_i = ~clk_i;

  freq_src_sel #(.CODE_W(CODE_W), .N_W(N_W), .M_W(M_W)) uut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "code", code_o, e_code);
    chk(tag, "n", n_o, e_n);
    chk(tag, "m", m_o, e_m);
    chk(tag, "nm", nm_o, e_nm);
    chk(tag, "src", src_o, e_src);
    chk(tag, "load", load_o, e_load);
    chk(tag, "chg", chg_o, e_chg);
    chk(tag, "err", err_o, e_err);
  endtask

  task automatic model();
    logic              ho, hs;
    logic [CODE_W-1:0] hw, c;
    logic [N_W-1:0]    hn, n;
    logic [M_W-1:0]    hm, m;
    logic              nm, bad, diff;
    logic [1:0]        s;
    ho = e_rec ? s_ovr : override_i;
    hs = e_rec ? s_sel : rcv_sel_i;
    hw = e_rec ? s_sw  : sw_code_i;
    hn = e_rec ? s_rn  : rcv_n_i;
    hm = e_rec ? s_rm  : rcv_m_i;
    e_load = 0; e_chg = 0; e_err = 0;
    if (e_lat) begin
      c = e_strap; n = '0; m = '0; nm = 0; s = 2'd0;
      if (recovery_i) begin
        if (hs) begin c = ho ? hw : e_strap; n = hn; m = hm; nm = 1; s = 2'd3; end
      end else if (prog_en_i) begin
        c = override_i ? sw_code_i : e_strap; n = prog_n_i; m = prog_m_i; nm = 1; s = 2'd2;
      end else if (override_i) begin
        c = sw_code_i; s = 2'd1;
      end
      bad = nm && (n <= {1'b0, m});
      if (bad) e_err = 1;
      else begin
        diff = (c != e_code) || (n != e_n) || (m != e_m) || (nm != e_nm);
        e_chg  = diff;
        e_load = diff || (!recovery_i && prog_en_i && (prog_n_we_i || prog_m_we_i));
        e_code = c; e_n = n; e_m = m; e_nm = nm; e_src = s;
      end
    end
    if (!e_lat && !pwrgd_ni) begin e_strap = strap_i; e_lat = 1; end
    if (recovery_i && !e_rec) begin
      s_ovr = override_i; s_sel = rcv_sel_i; s_sw = sw_code_i; s_rn = rcv_n_i; s_rm = rcv_m_i;
    end
    e_rec = recovery_i;
  endtask

  task automatic step(input string tag);
    model();
    @(posedge clk_i);
    @(negedge clk_i);
    chk_all(tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_ni = 0; strap_i = 5'h13; sw_code_i = '0; pwrgd_ni = 1; prog_en_i = 0;
    override_i = 0; prog_n_i = '0; prog_m_i = '0; prog_n_we_i = 0; prog_m_we_i = 0;
    recovery_i = 0; rcv_sel_i = 0; rcv_n_i = '0; rcv_m_i = '0;
    repeat (3) @(negedge clk_i);
    chk_all("R1");
    rst_ni = 1;
    // R1: no capture yet
    repeat (3) step("R1");
    // R2: capture 0x13, then ignore later strobes
    pwrgd_ni = 0; step("R2");
    pwrgd_ni = 1; strap_i = 5'h07; step("R2");
    chk("R2", "code captured", code_o, 5'h13);
    pwrgd_ni = 0; repeat (2) step("R2");
    chk("R2", "code frozen", code_o, 5'h13);
    // R3: software code
    override_i = 1; sw_code_i = 5'h0A; step("R3");
    chk("R3", "soft code", code_o, 5'h0A);
    override_i = 0; step("R3");
    // R4 / R5: programmed pair
    prog_n_i = 8'd200; prog_m_i = 7'd45; prog_en_i = 1; step("R4");
    chk("R5", "load on change", load_o, 1);
    // R6: rewrite same values
    prog_n_we_i = 1; step("R6");
    chk("R6", "load on rewrite", load_o, 1);
    chk("R6", "no change pulse", chg_o, 0);
    prog_n_we_i = 0; prog_m_we_i = 1; step("R6");
    prog_m_we_i = 0; step("R6");
    // R7: boundary N=M, N<M, then N=M+1
    prog_n_i = 8'd45; prog_n_we_i = 1; step("R7");
    chk("R7", "err at N=M", err_o, 1);
    chk("R7", "n held", n_o, 200);
    prog_n_i = 8'd10; step("R7");
    prog_n_i = 8'd46; step("R7");
    chk("R7", "accept N=M+1", n_o, 46);
    prog_n_we_i = 0;
    // R8: recovery with pair, override on
    override_i = 1; sw_code_i = 5'h1C; rcv_sel_i = 1; rcv_n_i = 8'd150; rcv_m_i = 7'd93;
    recovery_i = 1; step("R8");
    chk("R8", "rcv src", src_o, 3);
    // R9: lockout
    prog_n_i = 8'd99; prog_n_we_i = 1; override_i = 0; rcv_n_i = 8'd7; rcv_sel_i = 0;
    repeat (3) step("R9");
    chk("R9", "rcv n locked", n_o, 150);
    prog_n_we_i = 0;
    // R10: exit
    recovery_i = 0; step("R10");
    chk("R10", "live n", n_o, 99);
    // R8: recovery from straps
    prog_en_i = 0; rcv_sel_i = 0; recovery_i = 1; step("R8");
    chk("R8", "strap in rcv", code_o, 5'h13);
    recovery_i = 0; step("R10");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      string tag;
      pwrgd_ni = $urandom_range(0, 1);
      strap_i  = CODE_W'($urandom);
      if ($urandom_range(0, 7) == 0) override_i = ~override_i;
      if ($urandom_range(0, 5) == 0) sw_code_i = CODE_W'($urandom);
      if ($urandom_range(0, 15) == 0) prog_en_i = ~prog_en_i;
      prog_m_we_i = ($urandom_range(0, 7) == 0);
      prog_n_we_i = ($urandom_range(0, 7) == 0);
      if (prog_m_we_i) prog_m_i = M_W'($urandom);
      if (prog_n_we_i) prog_n_i = N_W'(prog_m_i + $urandom_range(0, 6)) - N_W'(1);
      if ($urandom_range(0, 31) == 0) recovery_i = ~recovery_i;
      rcv_sel_i = $urandom_range(0, 1);
      rcv_m_i   = M_W'($urandom);
      rcv_n_i   = N_W'(rcv_m_i + $urandom_range(0, 4)) - N_W'(1);
      tag = recovery_i ? "R9" : (prog_en_i ? "R4" : "R3");
      step(tag);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule